// File: doc/BRIEF.md
# Serial Debug Access Port (SPI slave with burst addressing)

This block gives an external SPI controller read and write access to a 16-bit word-addressed internal space. A frame opens when chip select goes low. The controller first sends an 8-bit command, then a 16-bit start address, and then as many 16-bit data words as it wants. Every bit travels most significant bit first. The block turns each frame into single-cycle strobes on a simple synchronous bus with address, write data, write strobe, read strobe and read data. While chip select stays low, each further word goes to the next address. Raising chip select ends the frame at once and throws away any word that is not complete.

All logic runs on the system clock. SCLK, chip select and MOSI each pass through a two-flop synchroniser, and SCLK edges are found in the system clock domain. A state machine steps through the frame phases. Its states are ST_IDLE, ST_CMD, ST_ADDR, ST_RLOAD, ST_RSHIFT, ST_WSHIFT, ST_WPULSE and ST_DISCARD. Its transitions are:

- select: ST_IDLE to ST_CMD.
- opcode accepted: ST_CMD to ST_ADDR.
- opcode rejected: ST_CMD to ST_DISCARD.
- address done: ST_ADDR to ST_RLOAD for a read, or to ST_WSHIFT for a write.
- fetched: ST_RLOAD to ST_RSHIFT.
- read word done: ST_RSHIFT to ST_RLOAD.
- write word done: ST_WSHIFT to ST_WPULSE.
- strobed: ST_WPULSE to ST_WSHIFT.
- deselect: any state to ST_IDLE when chip select is high. ST_WPULSE still issues its strobe in that case.

While the block is deselected, MISO shows whether the processor is stopped. It is never left floating.

Top module: `dbg_spi_slave`

## Requirements
- R1: After reset, with chip select high, neither bus strobe is asserted and MISO equals `cpu_halted_i`.
- R2: While chip select is high, MISO drives 0 when `cpu_halted_i` is 0 and 1 when it is 1. MISO is never high impedance.
- R3: MOSI is captured on rising SCLK edges, most significant bit first. The first 8 bits form the command and the next 16 bits form the start address.
- R4: Command 0x02 is a write. After the 16th bit of each complete data word, `bus_we_o` pulses for exactly one system clock. The pulse carries that word on `bus_wdata_o` and the word's address on `bus_addr_o`.
- R5: Command 0x03 is a read. After the 16th address bit, `bus_re_o` pulses for one clock at the start address. The returned word is then shifted out on MISO MSB first, and MISO changes after falling SCLK edges. The first bit appears after the falling edge that follows the last address bit. After each complete data word another read is issued, so a burst of N words makes N+1 read strobes.
- R6: Each further data word in a frame uses the previous address plus one, and the address wraps from 0xFFFF to 0x0000.
- R7: Any command other than 0x02 or 0x03 produces no bus strobe, and MISO stays 0 until chip select goes high.
- R8: Raising chip select ends the frame in any phase. A partly shifted word causes no strobe, and the next frame is decoded from its own first bit.
- R9: While selected, MISO drives 0 during the command, address and write-data phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the controller, idles low |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the controller |
| miso_o | output | 1 | Serial data to the controller, or the halt status while deselected |
| cpu_halted_i | input | 1 | 1 when the processor is stopped, 0 when it runs |
| bus_addr_o | output | 16 | Word address for the internal bus |
| bus_wdata_o | output | 16 | Write data, valid while `bus_we_o` is high |
| bus_we_o | output | 1 | Single-cycle write strobe |
| bus_re_o | output | 1 | Single-cycle read strobe |
| bus_rdata_i | input | 16 | Read data, valid in the same cycle as `bus_re_o` |

## Verification
The hardest situations to reach are chip select rising in the middle of a word, and a burst whose address crosses 0xFFFF. Both happen only after a long run of correctly timed serial bits. The bench drives whole frames bit by bit. It cuts some of them off after a chosen number of bits in the command, address and data phases, and then reads back neighbouring words to show that nothing was written. It also sweeps every one of the 254 rejected command codes with a full address and data phase, and checks that no strobe appears and MISO stays low.

// File: rtl/dbg_spi_pkg.sv
package dbg_spi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_RLOAD,
        ST_RSHIFT,
        ST_WSHIFT,
        ST_WPULSE,
        ST_DISCARD
    } dbg_state_e;

    localparam int unsigned DEF_CMD_W  = 8;
    localparam int unsigned DEF_ADDR_W = 16;
    localparam int unsigned DEF_DATA_W = 16;

endpackage

// File: rtl/dbg_spi_sync.sv
// Multi-bit bank of independent flop-chain synchronisers.
module dbg_spi_sync #(
    parameter int unsigned          W       = 3,
    parameter int unsigned          STAGES  = 2,
    parameter logic [W-1:0]         RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic [STAGES-1:0] chain_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RST_VAL[g]}};
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_i[g]};
                end
            end

            assign sync_o[g] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/dbg_spi_edge.sv
// Rising and falling edge detector on an already synchronised level.
module dbg_spi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
        end
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/dbg_spi_ctrl.sv
// Frame sequencer: command, address and word phases, bus strobes.
module dbg_spi_ctrl
    import dbg_spi_pkg::*;
#(
    parameter int unsigned     CMD_W  = DEF_CMD_W,
    parameter int unsigned     ADDR_W = DEF_ADDR_W,
    parameter int unsigned     DATA_W = DEF_DATA_W,
    parameter logic [CMD_W-1:0] RD_OP = 8'h03,
    parameter logic [CMD_W-1:0] WR_OP = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act_i,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              mosi_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_we_o,
    output logic              bus_re_o,
    output logic              tx_load_o,
    output logic              tx_shift_o,
    output logic              tx_clear_o
);

    localparam int unsigned SH_A = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int unsigned SH_W = (SH_A > CMD_W) ? SH_A : CMD_W;
    localparam int unsigned CNT_W = $clog2(SH_W);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    dbg_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [SH_W-1:0]   rx_q;
    logic [SH_W-1:0]   rx_next;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic [CNT_W-1:0]  last_idx;
    logic              shifting;
    logic              bit_last;
    logic [CMD_W-1:0]  cmd_word;
    logic              cmd_known;

    assign rx_next   = {rx_q[SH_W-2:0], mosi_i};
    assign cmd_word  = rx_next[CMD_W-1:0];
    assign cmd_known = (cmd_word == RD_OP) || (cmd_word == WR_OP);

    always_comb begin
        shifting = 1'b0;
        last_idx = DATA_LAST;
        unique case (state_q)
            ST_CMD:    begin shifting = 1'b1; last_idx = CMD_LAST;  end
            ST_ADDR:   begin shifting = 1'b1; last_idx = ADDR_LAST; end
            ST_RSHIFT: begin shifting = 1'b1; last_idx = DATA_LAST; end
            ST_WSHIFT: begin shifting = 1'b1; last_idx = DATA_LAST; end
            default:   begin shifting = 1'b0; last_idx = DATA_LAST; end
        endcase
    end

    assign bit_last = shifting && sck_rise_i && (cnt_q == last_idx);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_act_i) state_d = ST_CMD;
            end
            ST_CMD: begin
                if (!cs_act_i)     state_d = ST_IDLE;
                else if (bit_last) state_d = cmd_known ? ST_ADDR : ST_DISCARD;
            end
            ST_ADDR: begin
                if (!cs_act_i)     state_d = ST_IDLE;
                else if (bit_last) state_d = rd_q ? ST_RLOAD : ST_WSHIFT;
            end
            ST_RLOAD: begin
                state_d = cs_act_i ? ST_RSHIFT : ST_IDLE;
            end
            ST_RSHIFT: begin
                if (!cs_act_i)     state_d = ST_IDLE;
                else if (bit_last) state_d = ST_RLOAD;
            end
            ST_WSHIFT: begin
                if (!cs_act_i)     state_d = ST_IDLE;
                else if (bit_last) state_d = ST_WPULSE;
            end
            ST_WPULSE: begin
                state_d = cs_act_i ? ST_WSHIFT : ST_IDLE;
            end
            ST_DISCARD: begin
                if (!cs_act_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers: bit counter, receive shifter, opcode flag, address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rx_q   <= '0;
            rd_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            if (!cs_act_i || state_q == ST_IDLE || state_q == ST_DISCARD) begin
                cnt_q <= '0;
            end else if (shifting && sck_rise_i) begin
                cnt_q <= bit_last ? '0 : cnt_q + 1'b1;
            end

            if (sck_rise_i && (state_q == ST_CMD || state_q == ST_ADDR ||
                               state_q == ST_WSHIFT)) begin
                rx_q <= rx_next;
            end

            if (state_q == ST_CMD && bit_last) begin
                rd_q <= (cmd_word == RD_OP);
            end

            if (state_q == ST_ADDR && bit_last) begin
                addr_q <= rx_next[ADDR_W-1:0];
            end else if (state_q == ST_RSHIFT && bit_last) begin
                addr_q <= addr_q + 1'b1;
            end else if (state_q == ST_WPULSE) begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    // Output decode.
    always_comb begin
        bus_re_o    = (state_q == ST_RLOAD);
        bus_we_o    = (state_q == ST_WPULSE);
        tx_load_o   = (state_q == ST_RLOAD);
        tx_shift_o  = (state_q == ST_RSHIFT) && sck_fall_i;
        tx_clear_o  = (state_q == ST_IDLE);
        bus_addr_o  = addr_q;
        bus_wdata_o = rx_q[DATA_W-1:0];
    end

endmodule

// File: rtl/dbg_spi_tx.sv
// Transmit shifter and MISO level selection.
module dbg_spi_tx #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic              clear_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              cs_act_i,
    input  logic              halted_i,
    output logic              miso_o
);

    logic [DATA_W-1:0] tx_q;
    logic              miso_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            miso_q <= 1'b0;
        end else if (clear_i) begin
            tx_q   <= '0;
            miso_q <= 1'b0;
        end else if (load_i) begin
            tx_q <= rdata_i;
        end else if (shift_i) begin
            miso_q <= tx_q[DATA_W-1];
            tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    assign miso_o = cs_act_i ? miso_q : halted_i;

endmodule

// File: rtl/dbg_spi_slave.sv
module dbg_spi_slave
    import dbg_spi_pkg::*;
#(
    parameter int unsigned      CMD_W       = DEF_CMD_W,
    parameter int unsigned      ADDR_W      = DEF_ADDR_W,
    parameter int unsigned      DATA_W      = DEF_DATA_W,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [CMD_W-1:0] RD_OP       = 8'h03,
    parameter logic [CMD_W-1:0] WR_OP       = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic              cpu_halted_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_we_o,
    output logic              bus_re_o,
    input  logic [DATA_W-1:0] bus_rdata_i
);

    localparam int unsigned N_SYNC = 3;
    // bit 0: SCLK (idles low), bit 1: chip select (idles high), bit 2: MOSI
    localparam logic [N_SYNC-1:0] SYNC_RST = 3'b010;

    logic [N_SYNC-1:0] pins_s;
    logic              sck_s, csn_s, mosi_s, cs_act;
    logic              sck_rise, sck_fall;
    logic              tx_load, tx_shift, tx_clear;

    dbg_spi_sync #(
        .W       (N_SYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({mosi_i, csn_i, sclk_i}),
        .sync_o  (pins_s)
    );

    assign sck_s  = pins_s[0];
    assign csn_s  = pins_s[1];
    assign mosi_s = pins_s[2];
    assign cs_act = ~csn_s;

    dbg_spi_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sck_s),
        .rise_o (sck_rise),
        .fall_o (sck_fall)
    );

    dbg_spi_ctrl #(
        .CMD_W  (CMD_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RD_OP  (RD_OP),
        .WR_OP  (WR_OP)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_act_i    (cs_act),
        .sck_rise_i  (sck_rise),
        .sck_fall_i  (sck_fall),
        .mosi_i      (mosi_s),
        .bus_addr_o  (bus_addr_o),
        .bus_wdata_o (bus_wdata_o),
        .bus_we_o    (bus_we_o),
        .bus_re_o    (bus_re_o),
        .tx_load_o   (tx_load),
        .tx_shift_o  (tx_shift),
        .tx_clear_o  (tx_clear)
    );

    dbg_spi_tx #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tx_load),
        .shift_i  (tx_shift),
        .clear_i  (tx_clear),
        .rdata_i  (bus_rdata_i),
        .cs_act_i (cs_act),
        .halted_i (cpu_halted_i),
        .miso_o   (miso_o)
    );

endmodule

// File: rtl/dbg_spi_chk.sv
module dbg_spi_chk #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csn_i,
    input logic              cpu_halted_i,
    input logic              miso_o,
    input logic              bus_we_o,
    input logic              bus_re_o,
    input logic [ADDR_W-1:0] bus_addr_o
);

    // R2
    idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3))
        |-> (miso_o == cpu_halted_i));

    // R4
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we_o |=> !bus_we_o);

    // R5
    re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re_o |=> !bus_re_o);

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we_o |=> (bus_addr_o == $past(bus_addr_o) + ADDR_W'(1)));

    // R8
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3) && $past(csn_i, 4))
        |-> (!bus_we_o && !bus_re_o));

endmodule

bind dbg_spi_slave dbg_spi_chk #(
    .ADDR_W (ADDR_W)
) u_dbg_spi_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csn_i        (csn_i),
    .cpu_halted_i (cpu_halted_i),
    .miso_o       (miso_o),
    .bus_we_o     (bus_we_o),
    .bus_re_o     (bus_re_o),
    .bus_addr_o   (bus_addr_o)
);

// File: tb/test_dbg_spi_slave.sv
`timescale 1ns/1ps
module test_dbg_spi_slave;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        csn = 1'b1;
    logic        mosi = 1'b0;
    logic        halted = 1'b0;
    logic        miso;
    logic [15:0] addr, wdata, rdata;
    logic        we, re;

    logic [15:0] mem    [0:63];
    logic [15:0] shadow [0:63];
    logic [15:0] log_addr [0:63];
    logic [15:0] log_data [0:63];
    int we_cnt = 0;
    int re_cnt = 0;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dbg_spi_slave i_dbg_spi_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_i       (sclk),
        .csn_i        (csn),
        .mosi_i       (mosi),
        .miso_o       (miso),
        .cpu_halted_i (halted),
        .bus_addr_o   (addr),
        .bus_wdata_o  (wdata),
        .bus_we_o     (we),
        .bus_re_o     (re),
        .bus_rdata_i  (rdata)
    );

    function automatic logic [15:0] init_word(input int i);
        return 16'h4B00 + 16'(i) * 16'h0203;
    endfunction

    function automatic logic [15:0] wpat(input logic [15:0] a, input int w);
        return (a * 16'd7) ^ (16'(w) * 16'h1357) ^ 16'hA00F;
    endfunction

    assign rdata = mem[addr[5:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
        end else begin
            if (we) begin
                if (we_cnt < 64) begin
                    log_addr[we_cnt] <= addr;
                    log_data[we_cnt] <= wdata;
                end
                mem[addr[5:0]] <= wdata;
                we_cnt = we_cnt + 1;
            end
            if (re) re_cnt = re_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic s);
        mosi = b;
        repeat (HALF) @(negedge clk);
        s = miso;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic spi_field(input logic [15:0] v, input int n, output logic [15:0] got);
        logic s;
        got = '0;
        for (int i = n - 1; i >= 0; i--) begin
            spi_bit(v[i], s);
            got[i] = s;
        end
    endtask

    task automatic spi_begin();
        @(negedge clk);
        csn = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic spi_end();
        csn = 1'b1;
        mosi = 1'b0;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic do_write(input logic [15:0] a, input int n);
        logic [15:0] got;
        int w0 = we_cnt;
        spi_begin();
        spi_field(16'h0002, 8, got);
        spi_field(a, 16, got);
        for (int w = 0; w < n; w++) begin
            spi_field(wpat(a, w), 16, got);
            chk("R9 miso low during write data", 32'(got), 32'h0);
        end
        spi_end();
        chk("R4 write strobe count", 32'(we_cnt - w0), 32'(n));
        for (int w = 0; w < n; w++) begin
            logic [15:0] ea = a + 16'(w);
            chk("R6 write address", 32'(log_addr[w0 + w]), 32'(ea));
            chk("R3 write data", 32'(log_data[w0 + w]), 32'(wpat(a, w)));
            shadow[ea[5:0]] = wpat(a, w);
        end
    endtask

    task automatic do_read(input logic [15:0] a, input int n);
        logic [15:0] got;
        int r0 = re_cnt;
        spi_begin();
        spi_field(16'h0003, 8, got);
        spi_field(a, 16, got);
        for (int w = 0; w < n; w++) begin
            logic [15:0] ea = a + 16'(w);
            spi_field(16'hFFFF, 16, got);
            chk("R5 R6 read word", 32'(got), 32'(shadow[ea[5:0]]));
        end
        spi_end();
        chk("R5 read strobe count", 32'(re_cnt - r0), 32'(n + 1));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] got;
        int w0, r0;
        for (int i = 0; i < 64; i++) shadow[i] = init_word(i);
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk("R1 no write strobe", 32'(we), 32'h0);
        chk("R1 no read strobe", 32'(re), 32'h0);
        chk("R1 miso halt level", 32'(miso), 32'h0);
        // R2 idle level follows halt status
        halted = 1'b1; @(negedge clk);
        chk("R2 idle miso halted", 32'(miso), 32'h1);
        halted = 1'b0; @(negedge clk);
        chk("R2 idle miso running", 32'(miso), 32'h0);

        // R3 R4 R6 writes, including wrap past 0xFFFF
        do_write(16'h0000, 4);
        do_write(16'h0010, 1);
        do_write(16'h0023, 8);
        do_write(16'hFFFE, 4);
        do_write(16'h003C, 6);

        // R5 reads
        do_read(16'h0000, 4);
        do_read(16'h0020, 8);
        do_read(16'hFFFE, 4);
        do_read(16'h0005, 1);
        do_read(16'h0000, 64);

        halted = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 idle miso halted after read", 32'(miso), 32'h1);

        // R7 every rejected opcode, halt status high to tell apart from idle
        for (int c = 0; c < 256; c++) begin
            if (c != 2 && c != 3) begin
                logic [15:0] d;
                w0 = we_cnt; r0 = re_cnt;
                spi_begin();
                spi_field(16'(c), 8, got);
                spi_field(16'h0011, 16, got);
                spi_field(16'hFFFF, 16, d);
                spi_end();
                chk($sformatf("R7 opcode %02h strobes+miso", c),
                    {16'(we_cnt - w0 + re_cnt - r0), d}, 32'h0);
            end
        end
        halted = 1'b0;

        // R8 partial write word dropped
        w0 = we_cnt;
        spi_begin();
        spi_field(16'h0002, 8, got);
        spi_field(16'h0008, 16, got);
        spi_field(16'h1234, 16, got);
        spi_field(16'h5555, 9, got);
        spi_end();
        chk("R8 partial word strobes", 32'(we_cnt - w0), 32'h1);
        chk("R8 completed word address", 32'(log_addr[w0]), 32'h0008);
        shadow[8] = 16'h1234;
        do_read(16'h0008, 2);

        // R8 abort inside the address phase, then a fresh frame
        w0 = we_cnt; r0 = re_cnt;
        spi_begin();
        spi_field(16'h0002, 8, got);
        spi_field(16'h0030, 7, got);
        spi_end();
        chk("R8 aborted address strobes", 32'(we_cnt - w0 + re_cnt - r0), 32'h0);
        do_write(16'h0030, 1);

        // R8 abort inside the command phase, then a read
        r0 = re_cnt;
        spi_begin();
        spi_field(16'h0003, 3, got);
        spi_end();
        chk("R8 aborted command strobes", 32'(re_cnt - r0), 32'h0);
        do_read(16'h002F, 3);

        finish_run();
    end

endmodule